// File: doc/BRIEF.md
# Addressable Step-Attenuator Control Logic

This block is the digital front end of a 7-bit RF step attenuator. It holds the registered attenuation state that drives the switched attenuator array. Bit k of the state carries a weight of 0.25 dB × 2^k, so all ones means the maximum of 31.75 dB. A mode pin selects how the state is programmed.

With the mode pin low, the parallel bus programs the state. A latch-enable line makes the path transparent while it is high and holding while it is low. Tying it high gives direct control. Pulsing it high then low captures one value.

With the mode pin high, a 16-bit frame is shifted in on a serial clock while latch-enable is low. A rising latch-enable then loads the frame's attenuation field, but only if the frame's address field matches three strapped address pins. Several attenuators can therefore share one serial line.

All of the pins are asynchronous to the system clock. They pass through two-flop synchronizers, and the serial clock and latch edges are detected in the system clock domain. A one-cycle pulse marks every change of the state.

Top module: `step_atten_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `atten_o` is 7'h7F (maximum attenuation) and `upd_o` is 0.
- R2: In serial mode (`mode_sel_i`=1), a serial-clock rising edge with latch low shifts `sdata_i` in at the frame's MSB end. After 16 edges, the first bit sent sits at frame bit 0. Frame bits 6:0 are the attenuation field and frame bits 10:8 are the address field. A latch rising edge loads bits 6:0 into `atten_o` when bits 10:8 equal `addr_pins_i`.
- R3: A latch rising edge in serial mode whose frame address field differs from `addr_pins_i` leaves `atten_o` unchanged and gives no `upd_o` pulse.
- R4: Shifting with latch low never changes `atten_o`.
- R5: In parallel mode with latch high, `atten_o` follows `par_bus_i`. A bus change made between two system clock edges appears at `atten_o` on the third rising edge after it.
- R6: In parallel mode with latch low, bus changes are ignored. A high-then-low latch pulse captures the bus value present while latch was high.
- R7: `upd_o` is high for exactly one cycle on each cycle in which `atten_o` takes a new value. A load that writes the value already held gives no pulse.
- R8: A serial-clock rising edge that comes while latch is high, or in the same cycle that latch rises, does not shift. A coincident latch edge loads the frame as it was before that clock edge.
- R9: Frame bits 7 and 15:11 have no effect on the result.
- R10: In serial mode, the parallel bus and a high latch level do not drive `atten_o`. In parallel mode, the serial frame is never loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel_i | input | 1 | Programming mode: 0 parallel, 1 serial-addressable |
| sdata_i | input | 1 | Serial data input |
| sclk_i | input | 1 | Serial shift clock (sampled) |
| latch_i | input | 1 | Latch enable (sampled) |
| par_bus_i | input | 7 | Parallel attenuation control bus |
| addr_pins_i | input | 3 | Strapped device address |
| atten_o | output | 7 | Registered attenuation state, bit k weighs 0.25 dB × 2^k |
| upd_o | output | 1 | One-cycle pulse on every change of `atten_o` |

## Verification
The serial-clock rising edge and the latch rising edge can be detected in the same system cycle. That cycle would then carry both a shift and a load. The bench provokes this by driving `sclk_i` and `latch_i` high at the same instant after a matching frame has been shifted in. It judges the result by the loaded value: it must be the unshifted frame's field, because a shift would move the address field off the strapped pins. A second frame is then clocked in with latch held high, and a later latch pulse must still reload the earlier frame.

// File: rtl/satt_pkg.sv
package satt_pkg;
  localparam int ATT_W   = 7;  // attenuation state width
  localparam int ADR_W   = 3;  // significant address bits
  localparam int FIELD_W = 8;  // width of each half of a serial frame
  localparam int SYNC_N  = 2;  // synchronizer depth

  typedef enum logic {
    PROG_PAR = 1'b0,
    PROG_SER = 1'b1
  } prog_mode_e;
endpackage

// File: rtl/satt_sync.sv
// Multi-bit level synchronizer: DEPTH flops per bit, reset to zero.
module satt_sync #(
  parameter int W     = 4,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [DEPTH-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < DEPTH; k++) begin
        stg[k] <= stg[k-1];
      end
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/satt_rise.sv
// Rising-edge detection of already-synchronized levels.
module satt_rise #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign rise[b] = lvl[b] & ~prev[b];
  end
endmodule

// File: rtl/satt_shifter.sv
// Frame shift register, LSB first: new bits enter at the top end.
module satt_shifter #(
  parameter int FIELD_BITS = 8,
  parameter int ATT_BITS   = 7,
  parameter int ADDR_BITS  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [ATT_BITS-1:0]  att_fld,
  output logic [ADDR_BITS-1:0] adr_fld
);
  localparam int FRAME_BITS = 2 * FIELD_BITS;

  logic [FRAME_BITS-1:0] frame;

  always_ff @(posedge clk) begin
    if (rst)           frame <= '0;
    else if (shift_en) frame <= {bit_in, frame[FRAME_BITS-1:1]};
  end

  assign att_fld = frame[ATT_BITS-1:0];
  assign adr_fld = frame[FIELD_BITS +: ADDR_BITS];
endmodule

// File: rtl/satt_core.sv
// Attenuation state register with serial-addressed load and parallel latch.
module satt_core
  import satt_pkg::*;
#(
  parameter int ATT_BITS  = 7,
  parameter int ADDR_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  prog_mode_e           mode,
  input  logic                 le_lvl,
  input  logic                 le_rise,
  input  logic [ATT_BITS-1:0]  att_fld,
  input  logic [ADDR_BITS-1:0] adr_fld,
  input  logic [ADDR_BITS-1:0] addr_pins,
  input  logic [ATT_BITS-1:0]  par_s,
  output logic [ATT_BITS-1:0]  atten,
  output logic                 upd
);
  localparam logic [ATT_BITS-1:0] ATT_MAX = {ATT_BITS{1'b1}};

  logic [ATT_BITS-1:0] nxt;
  logic                addr_hit;

  assign addr_hit = (adr_fld == addr_pins);

  always_comb begin
    nxt = atten;
    case (mode)
      PROG_SER: if (le_rise && addr_hit) nxt = att_fld;
      default:  if (le_lvl)              nxt = par_s;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      atten <= ATT_MAX;
      upd   <= 1'b0;
    end else begin
      atten <= nxt;
      upd   <= (nxt != atten);
    end
  end
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import satt_pkg::*;
#(
  parameter int ATT_BITS   = ATT_W,
  parameter int ADDR_BITS  = ADR_W,
  parameter int FIELD_BITS = FIELD_W,
  parameter int SYNC_DEPTH = SYNC_N
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_sel_i,
  input  logic                 sdata_i,
  input  logic                 sclk_i,
  input  logic                 latch_i,
  input  logic [ATT_BITS-1:0]  par_bus_i,
  input  logic [ADDR_BITS-1:0] addr_pins_i,
  output logic [ATT_BITS-1:0]  atten_o,
  output logic                 upd_o
);
  localparam int CTRL_BITS = 4;
  localparam int IN_BITS   = CTRL_BITS + ATT_BITS;

  logic [IN_BITS-1:0]   raw_in;
  logic [IN_BITS-1:0]   syn;
  logic                 le_lvl, sclk_lvl, si_lvl, ser_lvl;
  logic [ATT_BITS-1:0]  par_s;
  logic [1:0]           rises;
  logic                 shift_en;
  logic [ATT_BITS-1:0]  att_fld;
  logic [ADDR_BITS-1:0] adr_fld;

  assign raw_in = {par_bus_i, mode_sel_i, sdata_i, sclk_i, latch_i};

  satt_sync #(.W(IN_BITS), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .din(raw_in), .dout(syn)
  );

  assign le_lvl   = syn[0];
  assign sclk_lvl = syn[1];
  assign si_lvl   = syn[2];
  assign ser_lvl  = syn[3];
  assign par_s    = syn[CTRL_BITS +: ATT_BITS];

  satt_rise #(.W(2)) u_rise (
    .clk(clk), .rst(rst), .lvl({sclk_lvl, le_lvl}), .rise(rises)
  );

  // shift only on a clock edge seen while latch is low
  assign shift_en = rises[1] & ~le_lvl;

  satt_shifter #(.FIELD_BITS(FIELD_BITS), .ATT_BITS(ATT_BITS), .ADDR_BITS(ADDR_BITS)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .bit_in(si_lvl),
    .att_fld(att_fld), .adr_fld(adr_fld)
  );

  satt_core #(.ATT_BITS(ATT_BITS), .ADDR_BITS(ADDR_BITS)) u_core (
    .clk(clk), .rst(rst), .mode(prog_mode_e'(ser_lvl)),
    .le_lvl(le_lvl), .le_rise(rises[0]),
    .att_fld(att_fld), .adr_fld(adr_fld), .addr_pins(addr_pins_i),
    .par_s(par_s), .atten(atten_o), .upd(upd_o)
  );
endmodule

// File: rtl/satt_chk.sv
module satt_chk #(
  parameter int ATT_BITS  = 7,
  parameter int ADDR_BITS = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ser_m,
  input logic                 le_lvl,
  input logic                 le_rise,
  input logic [ATT_BITS-1:0]  att_fld,
  input logic [ADDR_BITS-1:0] adr_fld,
  input logic [ADDR_BITS-1:0] pins,
  input logic [ATT_BITS-1:0]  par_s,
  input logic [ATT_BITS-1:0]  atten,
  input logic                 upd
);
  p_reset_max_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (atten == {ATT_BITS{1'b1}}) && !upd);

  p_match_load_r2: assert property (@(posedge clk) disable iff (rst)
    (ser_m && le_rise && adr_fld == pins) |=> atten == $past(att_fld));

  p_mismatch_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ser_m && le_rise && adr_fld != pins) |=> $stable(atten));

  p_shift_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ser_m && !le_rise) |=> $stable(atten));

  p_transparent_r5: assert property (@(posedge clk) disable iff (rst)
    (!ser_m && le_lvl) |=> atten == $past(par_s));

  p_latched_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!ser_m && !le_lvl) |=> $stable(atten));

  p_upd_on_change_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(atten) |-> upd);

  p_upd_only_change_r7: assert property (@(posedge clk) disable iff (rst)
    upd |-> !$stable(atten));
endmodule

bind step_atten_ctrl satt_chk #(.ATT_BITS(ATT_BITS), .ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk), .rst(rst), .ser_m(ser_lvl), .le_lvl(le_lvl), .le_rise(rises[0]),
  .att_fld(att_fld), .adr_fld(adr_fld), .pins(addr_pins_i), .par_s(par_s),
  .atten(atten_o), .upd(upd_o)
);

// File: tb/step_atten_ctrl_test.sv
module step_atten_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {pins[26:24], frame[23:8], expected atten[7:1], expected pulse[0]}
  localparam logic [26:0] VEC [NVEC] = '{
    {3'd3, 16'h0349, 7'h49, 1'b1},
    {3'd3, 16'h0510, 7'h49, 1'b0},
    {3'd3, 16'hF3AA, 7'h2A, 1'b1},
    {3'd3, 16'hF3AA, 7'h2A, 1'b0},
    {3'd3, 16'h0300, 7'h00, 1'b1},
    {3'd3, 16'h077F, 7'h00, 1'b0},
    {3'd7, 16'h077F, 7'h7F, 1'b1},
    {3'd0, 16'h0015, 7'h15, 1'b1}
  };
  localparam string VTAG [NVEC] = '{"R2", "R3", "R9", "R7", "R2", "R3", "R2", "R2"};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_sel = 1'b1;
  logic       sdata = 1'b0;
  logic       sclk = 1'b0;
  logic       latch = 1'b0;
  logic [6:0] par_bus = 7'h00;
  logic [2:0] addr_pins = 3'd0;
  logic [6:0] atten;
  logic       upd;

  int total = 0;
  int bad = 0;
  int upd_seen = 0;
  int base;

  step_atten_ctrl uut (
    .clk(clk), .rst(rst), .mode_sel_i(mode_sel), .sdata_i(sdata),
    .sclk_i(sclk), .latch_i(latch), .par_bus_i(par_bus),
    .addr_pins_i(addr_pins), .atten_o(atten), .upd_o(upd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (!rst && upd) upd_seen++;

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] fr);
    for (int i = 0; i < 16; i++) begin
      sdata = fr[i];
      wait_n(3);
      sclk = 1'b1;
      wait_n(3);
      sclk = 1'b0;
      wait_n(2);
    end
  endtask

  task automatic pulse_latch();
    latch = 1'b1;
    wait_n(4);
    latch = 1'b0;
    wait_n(6);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    wait_n(5);
    chk("R1 reset state", atten, 7'h7F);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle after reset", atten, 7'h7F);
    chk("R1 no pulse after reset", upd, 0);
    wait_n(4);

    // serial vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [6:0] prev_exp;
      prev_exp = (v == 0) ? 7'h7F : VEC[v-1][7:1];
      addr_pins = VEC[v][26:24];
      base = upd_seen;
      send_frame(VEC[v][23:8]);
      chk("R4 shifting holds state", atten, prev_exp);
      pulse_latch();
      chk(VTAG[v], atten, VEC[v][7:1]);
      chk({VTAG[v], " pulse count"}, upd_seen - base, VEC[v][0]);
    end

    // R8: coincident clock and latch edges, then clocks while latch high
    addr_pins = 3'd3;
    send_frame(16'h0305);
    pulse_latch();
    chk("R2 preload", atten, 7'h05);
    send_frame(16'h0311);
    sdata = 1'b1;
    sclk  = 1'b1;
    latch = 1'b1;
    wait_n(6);
    sclk = 1'b0;
    wait_n(4);
    chk("R8 coincident edges load unshifted frame", atten, 7'h11);
    base = upd_seen;
    send_frame(16'h0322);
    latch = 1'b0;
    wait_n(6);
    pulse_latch();
    chk("R8 clocks with latch high do not shift", atten, 7'h11);
    chk("R7 reload of same value gives no pulse", upd_seen - base, 0);

    // R10: serial mode ignores the parallel bus and latch level
    par_bus = 7'h55;
    latch = 1'b1;
    wait_n(10);
    chk("R10 serial mode ignores parallel bus", atten, 7'h11);
    latch = 1'b0;
    wait_n(6);

    // parallel mode
    mode_sel = 1'b0;
    wait_n(6);
    chk("R6 mode change with latch low holds", atten, 7'h11);
    par_bus = 7'h33;
    wait_n(6);
    chk("R6 bus ignored while latch low", atten, 7'h11);
    pulse_latch();
    chk("R6 latch pulse captures bus", atten, 7'h33);
    par_bus = 7'h0C;
    wait_n(6);
    chk("R6 bus ignored after latch fell", atten, 7'h33);
    latch = 1'b1;
    wait_n(8);
    chk("R5 transparent with latch high", atten, 7'h0C);
    par_bus = 7'h70;
    wait_n(2);
    chk("R5 not yet after two edges", atten, 7'h0C);
    wait_n(1);
    chk("R5 follows bus on third edge", atten, 7'h70);

    // R10: parallel mode never loads the serial frame
    latch = 1'b0;
    wait_n(4);
    send_frame(16'h0301);
    pulse_latch();
    chk("R10 parallel mode ignores serial frame", atten, 7'h70);

    // R1: reset mid-run
    rst = 1'b1;
    wait_n(3);
    chk("R1 reset returns to maximum", atten, 7'h7F);
    chk("R1 no pulse in reset", upd, 0);

    summary();
  end
endmodule